// File: doc/BRIEF.md
# Codec Response Ring Writer

This block is the controller-side engine that takes codec responses and places them in a circular response buffer in system memory, then tells the host that new responses are waiting. Each response comes in on a valid/ready input. It carries a 32-bit response payload and a 32-bit extended word. In the extended word, the low four bits name the codec that answered and bit 4 flags an unsolicited event. The engine stores the extended word exactly as it arrives.

Each accepted response moves the write pointer forward by one, wrapping at the ring size. The entry is then written to memory as two 32-bit words through a memory write port. The payload goes to byte offset 8·wp and the extended word to 8·wp+4. Both offsets are counted from a ring base that sits a fixed 2048 bytes above the command-ring base supplied on an input.

Interrupts can be coalesced. A status flag is raised after a programmable number N of completed entries, and an N of 0 means the full ring size. The host reaches four small registers through a simple write strobe and a combinational read port:

- the write pointer, which also carries a reset bit;
- the threshold N;
- the control bits;
- the status flag, which is cleared by writing 1.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset, the write pointer reads 0, the control register reads 0, the status bit reads 0, and `rsp_ready` and `irq` are both low.
- R2: While the DMA-enable bit (control register, address 2, bit 0) is 0, `rsp_ready` stays low and no memory write is issued.
- R3: For each accepted response, the write pointer first increments modulo 256. The payload is then written at byte address `cmd_base + 2048 + 8*wp` and the extended word at that address + 4, on two consecutive cycles.
- R4: Both words reach memory unchanged. This includes the codec address in extended bits [3:0] and the unsolicited flag in extended bit 4.
- R5: After 256 entries, the write pointer (address 0, bits [7:0]) returns to its starting value.
- R6: With N = 1 (address 1, bits [7:0]), every completed entry sets the status bit (address 3, bit 0).
- R7: With N = 3, the status bit stays 0 after two entries and becomes 1 on the third.
- R8: N = 0 acts as 256: the status bit stays 0 after 255 entries and is set by the 256th.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when the status bit is 1 and the interrupt-enable bit (address 2, bit 1) is 1.
- R11: Writing 1 to bit 15 of address 0 sets the write pointer to 0. The next entry then lands at index 1.
- R12: Control bit 0 reads 1 while DMA is enabled and reads 0 once DMA is disabled and no entry is still being written.
- R13: Address 3 bits [5:4] read the fixed ring-size code 2'b10, which selects 256 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_base | input | 32 | Byte base address of the command ring |
| rsp_valid | input | 1 | Response available |
| rsp_ready | output | 1 | Engine accepts a response this cycle |
| rsp_data | input | 32 | Response payload |
| rsp_ext | input | 32 | Extended word: [3:0] codec address, [4] unsolicited flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer, 1 threshold, 2 control, 3 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory byte address |
| mem_wr_data | output | 32 | Memory write data |
| irq | output | 1 | Response interrupt |

## Verification
Single responses are sent with distinct payloads and with extended words that differ in codec address and unsolicited flag. Placing two of these entries side by side at known indices separates a correct address calculation from pointer-before-write or payload/extended-word swap errors. The threshold is exercised with N = 1, N = 3 and N = 0. This shows the difference between per-entry interrupts, true coalescing, and the "zero means full ring" case, which is observed across a full 256-entry lap that also checks pointer wraparound. Separate scenarios hold `rsp_valid` high with DMA off, toggle interrupt enable against a set status bit, write 0 and then 1 to the status bit, and pulse the pointer-reset bit. These isolate the gating and clearing paths from the data path.

// File: rtl/rrw_pkg.sv
// Package: shared register addresses and field positions for the response
// ring writer. Assumes a four-entry register space and 16-bit register data.
package rrw_pkg;
    localparam logic [1:0] REG_WP     = 2'd0;
    localparam logic [1:0] REG_THRESH = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;
    localparam logic [1:0] REG_STAT   = 2'd3;

    localparam int WP_RST_BIT  = 15;
    localparam int CTRL_DMA    = 0;
    localparam int CTRL_IRQ    = 1;
    localparam int STAT_FLAG   = 0;

    localparam logic [1:0] SIZE_CODE_256 = 2'b10;
endpackage

// File: rtl/rrw_regs.sv
// Register block: holds the DMA/interrupt enables, the coalescing threshold
// and the write-1-to-clear status flag, and serves combinational reads.
// Assumes the pointer value comes from the entry sequencer.
module rrw_regs #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    input  logic [PTR_W-1:0] wp,
    input  logic             engine_busy,
    input  logic             thresh_hit,
    output logic             dma_en,
    output logic             irq_en,
    output logic [PTR_W-1:0] thresh,
    output logic             status,
    output logic             wp_clr,
    output logic [15:0]      reg_rdata,
    output logic             irq
);
    import rrw_pkg::*;

    logic wr_ctrl, wr_thr, wr_stat;

    // Decode the write strobes per register.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
        wr_thr  = reg_wr && (reg_addr == REG_THRESH);
        wr_stat = reg_wr && (reg_addr == REG_STAT);
        wp_clr  = reg_wr && (reg_addr == REG_WP) && reg_wdata[WP_RST_BIT];
    end

    // Enable and threshold storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
            irq_en <= 1'b0;
            thresh <= PTR_W'(1);
        end else begin
            if (wr_ctrl) begin
                dma_en <= reg_wdata[CTRL_DMA];
                irq_en <= reg_wdata[CTRL_IRQ];
            end
            if (wr_thr)
                thresh <= reg_wdata[PTR_W-1:0];
        end
    end

    // Status flag: a threshold hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (thresh_hit)
            status <= 1'b1;
        else if (wr_stat && reg_wdata[STAT_FLAG])
            status <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_WP:     reg_rdata[PTR_W-1:0] = wp;
            REG_THRESH: reg_rdata[PTR_W-1:0] = thresh;
            REG_CTRL: begin
                reg_rdata[CTRL_DMA] = dma_en || engine_busy;
                reg_rdata[CTRL_IRQ] = irq_en;
            end
            REG_STAT: begin
                reg_rdata[STAT_FLAG] = status;
                reg_rdata[5:4]       = SIZE_CODE_256;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Interrupt output.
    always_comb irq = status && irq_en;
endmodule

// File: rtl/rrw_entry_seq.sv
// Entry sequencer: accepts one response, advances the write pointer
// modulo the ring size and emits the two words of the entry on
// consecutive cycles. Assumes ENTRIES is a power of two and the memory
// port accepts a write every cycle.
module rrw_entry_seq #(
    parameter int ENTRIES     = 256,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int RING_OFFSET = 2048,
    localparam int PTR_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              wp_clr,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [DATA_W-1:0] rsp_ext,
    output logic [PTR_W-1:0]  wp,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              word1_q,
    output logic              entry_done,
    output logic              busy
);
    logic              pending;
    logic [DATA_W-1:0] ext_q;
    logic [PTR_W-1:0]  wp_next;
    logic              accept;

    // Handshake and next pointer.
    always_comb begin
        rsp_ready  = dma_en && !pending && !wp_clr;
        accept     = rsp_valid && rsp_ready;
        wp_next    = wp + PTR_W'(1);
        entry_done = pending;
        busy       = pending || mem_wr_en;
    end

    // Write pointer: a reset request wins, otherwise advance on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp <= '0;
        else if (wp_clr)
            wp <= '0;
        else if (accept)
            wp <= wp_next;
    end

    // Two-beat memory write of the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending     <= 1'b0;
            ext_q       <= '0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            word1_q     <= 1'b0;
        end else if (pending) begin
            pending     <= 1'b0;
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= mem_wr_addr + ADDR_W'(4);
            mem_wr_data <= ext_q;
            word1_q     <= 1'b1;
        end else if (accept) begin
            pending     <= 1'b1;
            ext_q       <= rsp_ext;
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= cmd_base + ADDR_W'(RING_OFFSET) + (ADDR_W'(wp_next) << 3);
            mem_wr_data <= rsp_data;
            word1_q     <= 1'b0;
        end else begin
            mem_wr_en   <= 1'b0;
            word1_q     <= 1'b0;
        end
    end
endmodule

// File: rtl/rrw_coalesce.sv
// Coalescing counter: counts completed entries and flags a hit when the
// count reaches the threshold, then restarts. A threshold of 0 stands for
// the full ring size.
module rrw_coalesce #(
    parameter int ENTRIES = 256,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_done,
    input  logic [PTR_W-1:0] thresh,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_inc;

    // Effective target and hit detect.
    always_comb begin
        target  = (thresh == '0) ? CNT_W'(ENTRIES) : {1'b0, thresh};
        cnt_inc = cnt + CNT_W'(1);
        hit     = entry_done && (cnt_inc >= target);
    end

    // Entry count since the last hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (hit)
            cnt <= '0;
        else if (entry_done)
            cnt <= cnt_inc;
    end
endmodule

// File: rtl/rsp_ring_writer.sv
// Top: response ring writer. Joins the register block, the entry
// sequencer and the coalescing counter. Assumes a 256-entry ring at a
// fixed offset above the command-ring base.
module rsp_ring_writer #(
    parameter int ENTRIES     = 256,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int RING_OFFSET = 2048,
    localparam int PTR_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [DATA_W-1:0] rsp_ext,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              irq
);
    logic             dma_en, irq_en, status, wp_clr;
    logic             entry_done, busy, hit, word1_q;
    logic [PTR_W-1:0] wp, thresh;

    rrw_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wp(wp), .engine_busy(busy), .thresh_hit(hit),
        .dma_en(dma_en), .irq_en(irq_en), .thresh(thresh), .status(status),
        .wp_clr(wp_clr), .reg_rdata(reg_rdata), .irq(irq)
    );

    rrw_entry_seq #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RING_OFFSET(RING_OFFSET)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .wp_clr(wp_clr),
        .cmd_base(cmd_base), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_ext(rsp_ext), .wp(wp),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .word1_q(word1_q),
        .entry_done(entry_done), .busy(busy)
    );

    rrw_coalesce #(.ENTRIES(ENTRIES)) u_coal (
        .clk(clk), .rst_n(rst_n), .entry_done(entry_done),
        .thresh(thresh), .hit(hit)
    );
endmodule

// File: rtl/rsp_ring_writer_chk.sv
// Checker: temporal properties of the response ring writer, bound to
// the top module.
module rsp_ring_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        mem_wr_en,
    input logic [31:0] mem_wr_addr,
    input logic [31:0] mem_wr_data,
    input logic        irq,
    input logic        dma_en,
    input logic        irq_en,
    input logic        status,
    input logic        hit,
    input logic        word1_q
);
    // R2
    ready_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> dma_en);

    // R3
    second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !word1_q) |=>
            (mem_wr_en && word1_q && mem_wr_addr == $past(mem_wr_addr) + 32'd4));

    // R4
    payload_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (mem_wr_en && mem_wr_data == $past(rsp_data)));

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && reg_wdata[0] && !hit) |=> !status);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && irq_en));
endmodule

bind rsp_ring_writer rsp_ring_writer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .irq(irq), .dma_en(dma_en), .irq_en(irq_en),
    .status(status), .hit(hit), .word1_q(word1_q)
);

// File: tb/rsp_ring_writer_bench.sv
module rsp_ring_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_base = 32'h0001_0000;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_data = '0;
    logic [31:0] rsp_ext = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    int writes = 0;
    logic [31:0] mem_model [logic [31:0]];

    always #10 clk = ~clk;

    rsp_ring_writer u_rsp_ring_writer (
        .clk(clk), .rst_n(rst_n), .cmd_base(cmd_base), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .irq(irq)
    );

    // Memory model capturing every write.
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem_model[mem_wr_addr] = mem_wr_data;
            writes++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(logic [31:0] d, logic [31:0] e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = d; rsp_ext = e;
        while (!rsp_ready) @(negedge clk);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] slot(int idx);
        return cmd_base + 32'd2048 + 32'(idx) * 32'd8;
    endfunction

    task automatic t_reset;
        logic [15:0] v;
        rd_reg(2'd0, v); check("R1 wp", 32'(v), 0);
        rd_reg(2'd2, v); check("R1 ctrl", 32'(v), 0);
        rd_reg(2'd3, v); check("R1 status", 32'(v[0]), 0);
        check("R1 ready", 32'(rsp_ready), 0);
        check("R1 irq", 32'(irq), 0);
        rd_reg(2'd3, v); check("R13 size code", 32'(v[5:4]), 2);
    endtask

    task automatic t_dma_off;
        int w0;
        w0 = writes;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 32'hDEAD; rsp_ext = 32'h1;
        repeat (5) begin
            @(negedge clk);
            check("R2 ready low", 32'(rsp_ready), 0);
        end
        rsp_valid = 1'b0;
        check("R2 no writes", 32'(writes - w0), 0);
    endtask

    task automatic t_first_entries;
        logic [15:0] v;
        wr_reg(2'd2, 16'h0001);
        rd_reg(2'd2, v); check("R12 ctrl dma on", 32'(v[0]), 1);
        send(32'hCAFE_0001, 32'h0000_0003);
        rd_reg(2'd0, v); check("R3 wp after one", 32'(v), 1);
        check("R3 payload slot1", mem_model.exists(slot(1)) ? mem_model[slot(1)] : 32'hX, 32'hCAFE_0001);
        check("R4 ext slot1", mem_model.exists(slot(1) + 4) ? mem_model[slot(1) + 4] : 32'hX, 32'h0000_0003);
        check("R3 slot0 untouched", 32'(mem_model.exists(slot(0))), 0);
        send(32'h1234_5678, 32'h0000_0015);
        check("R4 unsol ext slot2", mem_model[slot(2) + 4], 32'h0000_0015);
        check("R4 payload slot2", mem_model[slot(2)], 32'h1234_5678);
        rd_reg(2'd3, v); check("R6 status N=1", 32'(v[0]), 1);
    endtask

    task automatic t_w1c_irq;
        logic [15:0] v;
        check("R10 irq masked", 32'(irq), 0);
        wr_reg(2'd2, 16'h0003);
        #1 check("R10 irq enabled", 32'(irq), 1);
        wr_reg(2'd3, 16'h0000);
        rd_reg(2'd3, v); check("R9 write0 keeps", 32'(v[0]), 1);
        wr_reg(2'd3, 16'h0001);
        rd_reg(2'd3, v); check("R9 write1 clears", 32'(v[0]), 0);
        check("R10 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_thresh3;
        logic [15:0] v;
        wr_reg(2'd1, 16'd3);
        send(32'hA1, 32'h2); send(32'hA2, 32'h2);
        rd_reg(2'd3, v); check("R7 two entries", 32'(v[0]), 0);
        send(32'hA3, 32'h2);
        rd_reg(2'd3, v); check("R7 third entry", 32'(v[0]), 1);
        wr_reg(2'd3, 16'h0001);
    endtask

    task automatic t_full_lap;
        logic [15:0] v, start;
        wr_reg(2'd1, 16'd0);
        rd_reg(2'd0, start);
        for (int i = 0; i < 255; i++) send(32'(i), 32'h1);
        rd_reg(2'd3, v); check("R8 after 255", 32'(v[0]), 0);
        send(32'hFF, 32'h1);
        rd_reg(2'd3, v); check("R8 after 256", 32'(v[0]), 1);
        rd_reg(2'd0, v); check("R5 wp wrapped", 32'(v), 32'(start));
        wr_reg(2'd3, 16'h0001);
    endtask

    task automatic t_wp_reset;
        logic [15:0] v;
        wr_reg(2'd0, 16'h8000);
        rd_reg(2'd0, v); check("R11 wp cleared", 32'(v), 0);
        send(32'hBEEF_0011, 32'h4);
        check("R11 next at slot1", mem_model[slot(1)], 32'hBEEF_0011);
        rd_reg(2'd0, v); check("R11 wp one", 32'(v), 1);
    endtask

    task automatic t_dma_stop;
        logic [15:0] v;
        wr_reg(2'd2, 16'h0000);
        repeat (2) @(posedge clk);
        rd_reg(2'd2, v); check("R12 ctrl dma off", 32'(v[0]), 0);
        check("R2 ready after stop", 32'(rsp_ready), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_dma_off();
        t_first_entries();
        t_w1c_irq();
        t_thresh3();
        t_full_lap();
        t_wp_reset();
        t_dma_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule